// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block owns the queueing state of a small set of outgoing message buffers in a CAN-style controller. Software gives each buffer a 2-bit priority and raises or drops its request bit. Whenever requests are pending and no frame is in flight, the block offers the winning buffer index to an external frame transmitter. While the offer waits for acceptance, it keeps re-evaluating the winner, so late priority or request changes take effect right up to start-of-frame. Once the transmitter accepts, the chosen index is frozen until the transmitter reports one outcome: sent, error or arbitration loss.

A failed attempt leaves the request standing and records why it failed. A single-buffer abort or a global abort cancels waiting buffers at once. A buffer that is on the bus runs on. If it completes, it finishes normally. If it fails, it is cancelled. Successful sends raise a sticky per-buffer completion interrupt when that buffer's enable is set.

Top module: `tx_sched`

## Requirements
- R1: After reset every request, priority, abort, lost, error and completion flag is 0, the global abort flag is 0 and `tx_start` is 0.
- R2: A request set at a clock edge while no frame is offered or in flight makes `tx_start` 1 after that same edge. `tx_idx` then names the pending buffer with the highest priority, where 3 is highest and 0 is lowest.
- R3: Among pending buffers of equal priority, the lowest index is offered.
- R4: Setting the request of a buffer that is not on the bus clears that buffer's abort, lost and error flags.
- R5: While `tx_start` is 1 and not yet accepted, `tx_idx` follows priority and request changes one edge later. After the accepting edge (`tx_start` and `tx_ack` both 1), `tx_start` drops. The next result then applies to the accepted buffer, even if priorities change in between.
- R6: On `tx_done` for the accepted buffer, its request clears. Its completion flag `done_irq` sets only if its `done_ie` bit is 1. `done_clr` clears completion flags.
- R7: On `tx_err`, the error flag sets and the request stays set, with no completion flag. The buffer is offered again.
- R8: On `tx_lost`, the lost flag sets and the request stays set, with no completion flag.
- R9: Pulsing `req_clr` on a pending buffer that is not on the bus clears its request and sets its abort flag without a completion flag. If nothing else is pending, `tx_start` drops after that edge.
- R10: `abort_all_set` cancels every pending buffer that is not on the bus. `abort_all_q` rises after that edge and stays 1 while a buffer on the bus carries an outstanding abort. It falls at the edge that resolves the abort. When no buffer is on the bus, it is 1 for exactly one cycle.
- R11: An aborted buffer on the bus that then completes behaves as a normal success. Its request clears, its abort flag stays 0 and its completion flag follows `done_ie`. If it instead fails, its request clears and its abort flag sets.
- R12: `tx_ack` is ignored unless `tx_start` is 1, and `tx_done`, `tx_err` and `tx_lost` are ignored unless a frame has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_we | input | N | Per-buffer priority write strobe |
| pri_wdata | input | N*PW | Priority data, buffer i at bits [PW*i+PW-1:PW*i] |
| req_set | input | N | Pulse: queue buffer i |
| req_clr | input | N | Pulse: abort buffer i |
| abort_all_set | input | 1 | Pulse: abort all pending buffers |
| done_ie | input | N | Completion interrupt enable per buffer |
| done_clr | input | N | Pulse: clear completion flag i |
| tx_ack | input | 1 | Transmitter accepts the offered buffer (start-of-frame) |
| tx_done | input | 1 | Accepted frame sent successfully |
| tx_err | input | 1 | Accepted frame hit a transmit error |
| tx_lost | input | 1 | Accepted frame lost arbitration |
| tx_start | output | 1 | Offer to the transmitter is valid |
| tx_idx | output | IW | Index of the offered buffer |
| req_q | output | N | Request bits |
| pri_q | output | N*PW | Priority fields |
| abt_q | output | N | Abort flags |
| lost_q | output | N | Arbitration-loss flags |
| err_q | output | N | Error flags |
| done_irq | output | N | Sticky completion interrupt flags |
| abort_all_q | output | 1 | Global abort in progress |

## Verification
A wrong winner shows up as a bad `tx_idx` in the same cycle the offer appears. The scoreboard compares every accepted index against the expected one. A lost or stale abort mark on the buffer on the bus only surfaces at its result edge, as a wrong request, abort flag or `abort_all_q` one cycle later. The bench therefore checks those right after each outcome. Results or acknowledges applied in the wrong phase leave visible traces in `req_q` and `done_irq`, so spurious pulses are followed by an immediate check of both.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OFFER = 2'd1,
    S_BUSY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tx_sched_arb.sv
// Combinational winner pick: highest priority, lowest index on ties.
module tx_sched_arb #(
  parameter int N  = 3,
  parameter int PW = 2,
  parameter int IW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri,
  output logic            any,
  output logic [IW-1:0]   win
);
  logic [PW-1:0] best_pri;
  logic          found;

  always_comb begin
    win      = '0;
    best_pri = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (pri[i*PW +: PW] > best_pri))) begin
        found    = 1'b1;
        best_pri = pri[i*PW +: PW];
        win      = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/tx_sched_slot.sv
// State of one transmit buffer: request, priority, status and abort mark.
module tx_sched_slot #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pri_we,
  input  logic [PW-1:0] pri_wdata,
  input  logic          req_set,
  input  logic          req_clr,
  input  logic          abort_all,
  input  logic          is_active,
  input  logic          res_done,
  input  logic          res_err,
  input  logic          res_lost,
  input  logic          ie,
  input  logic          done_clr,
  output logic          req_q,
  output logic [PW-1:0] pri_q,
  output logic          abt_q,
  output logic          lost_q,
  output logic          err_q,
  output logic          done_q,
  output logic          req_d,
  output logic [PW-1:0] pri_d,
  output logic          kill_d
);
  logic kill_q;
  logic abt_d, lost_d, err_d, done_d;
  logic abort_evt;

  always_comb begin
    abort_evt = req_clr | abort_all;
    req_d  = req_q;
    abt_d  = abt_q;
    lost_d = lost_q;
    err_d  = err_q;
    kill_d = kill_q;
    done_d = done_q & ~done_clr;
    pri_d  = pri_we ? pri_wdata : pri_q;
    if (is_active) begin
      if (res_done) begin
        req_d  = 1'b0;
        kill_d = 1'b0;
        if (ie) done_d = 1'b1;
      end else if (res_err || res_lost) begin
        err_d  = err_q | res_err;
        lost_d = lost_q | res_lost;
        if (kill_q || abort_evt) begin
          req_d = 1'b0;
          abt_d = 1'b1;
        end
        kill_d = 1'b0;
      end else if (abort_evt) begin
        kill_d = 1'b1;
      end
    end else begin
      if (req_set) begin
        req_d  = 1'b1;
        abt_d  = 1'b0;
        lost_d = 1'b0;
        err_d  = 1'b0;
      end
      if (abort_evt && (req_q || req_set)) begin
        req_d = 1'b0;
        abt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pri_q  <= '0;
      abt_q  <= 1'b0;
      lost_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pri_q  <= pri_d;
      abt_q  <= abt_d;
      lost_q <= lost_d;
      err_q  <= err_d;
      done_q <= done_d;
      kill_q <= kill_d;
    end
  end
endmodule

// File: rtl/tx_sched_seq.sv
// Offer / in-flight sequencer towards the frame transmitter.
module tx_sched_seq
  import tx_sched_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_req,
  input  logic [IW-1:0] win,
  input  logic          tx_ack,
  input  logic          res_any,
  output logic          tx_start_q,
  output logic [IW-1:0] tx_idx_q,
  output logic [IW-1:0] act_q,
  output logic          busy,
  output logic          ack_now
);
  seq_state_e state_q;

  assign busy    = (state_q == S_BUSY);
  assign ack_now = (state_q == S_OFFER) && tx_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      tx_start_q <= 1'b0;
      tx_idx_q   <= '0;
      act_q      <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (any_req) begin
            state_q    <= S_OFFER;
            tx_start_q <= 1'b1;
            tx_idx_q   <= win;
          end
        end
        S_OFFER: begin
          if (tx_ack) begin
            state_q    <= S_BUSY;
            tx_start_q <= 1'b0;
            act_q      <= tx_idx_q;
          end else if (any_req) begin
            tx_idx_q <= win;
          end else begin
            state_q    <= S_IDLE;
            tx_start_q <= 1'b0;
          end
        end
        S_BUSY: begin
          if (res_any) begin
            if (any_req) begin
              state_q    <= S_OFFER;
              tx_start_q <= 1'b1;
              tx_idx_q   <= win;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: begin
          state_q    <= S_IDLE;
          tx_start_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tx_sched.sv
module tx_sched #(
  parameter int N  = 3,
  parameter int PW = 2,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    pri_we,
  input  logic [N*PW-1:0] pri_wdata,
  input  logic [N-1:0]    req_set,
  input  logic [N-1:0]    req_clr,
  input  logic            abort_all_set,
  input  logic [N-1:0]    done_ie,
  input  logic [N-1:0]    done_clr,
  input  logic            tx_ack,
  input  logic            tx_done,
  input  logic            tx_err,
  input  logic            tx_lost,
  output logic            tx_start,
  output logic [IW-1:0]   tx_idx,
  output logic [N-1:0]    req_q,
  output logic [N*PW-1:0] pri_q,
  output logic [N-1:0]    abt_q,
  output logic [N-1:0]    lost_q,
  output logic [N-1:0]    err_q,
  output logic [N-1:0]    done_irq,
  output logic            abort_all_q
);
  logic [N-1:0]    req_d;
  logic [N*PW-1:0] pri_d;
  logic [N-1:0]    kill_d;
  logic [N-1:0]    is_active;
  logic            any_req;
  logic [IW-1:0]   win;
  logic [IW-1:0]   act;
  logic            busy;
  logic            ack_now;
  logic            res_any;

  assign res_any = tx_done | tx_err | tx_lost;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic sel_act;
    assign sel_act      = busy && (act == IW'(i));
    assign is_active[i] = sel_act || (ack_now && (tx_idx == IW'(i)));

    tx_sched_slot #(.PW(PW)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .pri_we    (pri_we[i]),
      .pri_wdata (pri_wdata[i*PW +: PW]),
      .req_set   (req_set[i]),
      .req_clr   (req_clr[i]),
      .abort_all (abort_all_set),
      .is_active (is_active[i]),
      .res_done  (sel_act && tx_done),
      .res_err   (sel_act && tx_err),
      .res_lost  (sel_act && tx_lost),
      .ie        (done_ie[i]),
      .done_clr  (done_clr[i]),
      .req_q     (req_q[i]),
      .pri_q     (pri_q[i*PW +: PW]),
      .abt_q     (abt_q[i]),
      .lost_q    (lost_q[i]),
      .err_q     (err_q[i]),
      .done_q    (done_irq[i]),
      .req_d     (req_d[i]),
      .pri_d     (pri_d[i*PW +: PW]),
      .kill_d    (kill_d[i])
    );
  end

  tx_sched_arb #(.N(N), .PW(PW), .IW(IW)) u_arb (
    .req (req_d),
    .pri (pri_d),
    .any (any_req),
    .win (win)
  );

  tx_sched_seq #(.IW(IW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .any_req    (any_req),
    .win        (win),
    .tx_ack     (tx_ack),
    .res_any    (res_any),
    .tx_start_q (tx_start),
    .tx_idx_q   (tx_idx),
    .act_q      (act),
    .busy       (busy),
    .ack_now    (ack_now)
  );

  always_ff @(posedge clk) begin
    if (rst) abort_all_q <= 1'b0;
    else     abort_all_q <= abort_all_set | (abort_all_q & (|kill_d));
  end
endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req_set,
  input logic [N-1:0]  req_clr,
  input logic          abort_all_set,
  input logic          tx_ack,
  input logic          tx_start,
  input logic [IW-1:0] tx_idx,
  input logic [N-1:0]  req_q,
  input logic [N-1:0]  abt_q,
  input logic [N-1:0]  lost_q,
  input logic [N-1:0]  err_q,
  input logic [N-1:0]  done_irq
);
  a_r2_start_has_req: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (|req_q));

  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (int'(tx_idx) < N));

  a_r5_ack_drops_start: assert property (@(posedge clk) disable iff (rst)
    (tx_start && tx_ack) |=> !tx_start);

  for (genvar i = 0; i < N; i++) begin : g_buf
    a_r4_set_clears: assert property (@(posedge clk) disable iff (rst)
      (req_set[i] && !req_clr[i] && !abort_all_set && !req_q[i])
        |=> (!abt_q[i] && !lost_q[i] && !err_q[i]));

    a_r6_irq_on_clear: assert property (@(posedge clk) disable iff (rst)
      $rose(done_irq[i]) |-> (!req_q[i] && $past(req_q[i])));

    a_r9_abort_clears_req: assert property (@(posedge clk) disable iff (rst)
      $rose(abt_q[i]) |-> !req_q[i]);

    a_r8_lost_no_irq: assert property (@(posedge clk) disable iff (rst)
      $rose(lost_q[i]) |-> !$rose(done_irq[i]));

    a_r7_err_keeps_req: assert property (@(posedge clk) disable iff (rst)
      ($rose(err_q[i]) && !abt_q[i]) |-> req_q[i]);
  end
endmodule

bind tx_sched tx_sched_chk #(.N(N), .IW(IW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_set       (req_set),
  .req_clr       (req_clr),
  .abort_all_set (abort_all_set),
  .tx_ack        (tx_ack),
  .tx_start      (tx_start),
  .tx_idx        (tx_idx),
  .req_q         (req_q),
  .abt_q         (abt_q),
  .lost_q        (lost_q),
  .err_q         (err_q),
  .done_irq      (done_irq)
);

// File: tb/tx_sched_tb.sv
`timescale 1ns/1ps
module tx_sched_tb;
  localparam int N  = 3;
  localparam int PW = 2;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    pri_we = '0;
  logic [N*PW-1:0] pri_wdata = '0;
  logic [N-1:0]    req_set = '0;
  logic [N-1:0]    req_clr = '0;
  logic            abort_all_set = 1'b0;
  logic [N-1:0]    done_ie = '0;
  logic [N-1:0]    done_clr = '0;
  logic            tx_ack = 1'b0;
  logic            tx_done = 1'b0;
  logic            tx_err = 1'b0;
  logic            tx_lost = 1'b0;
  logic            tx_start;
  logic [IW-1:0]   tx_idx;
  logic [N-1:0]    req_q, abt_q, lost_q, err_q, done_irq;
  logic [N*PW-1:0] pri_q;
  logic            abort_all_q;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  tx_sched #(.N(N), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .req_set(req_set), .req_clr(req_clr), .abort_all_set(abort_all_set),
    .done_ie(done_ie), .done_clr(done_clr), .tx_ack(tx_ack),
    .tx_done(tx_done), .tx_err(tx_err), .tx_lost(tx_lost),
    .tx_start(tx_start), .tx_idx(tx_idx), .req_q(req_q), .pri_q(pri_q),
    .abt_q(abt_q), .lost_q(lost_q), .err_q(err_q), .done_irq(done_irq),
    .abort_all_q(abort_all_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Monitor: each accepted offer is compared with the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && tx_start && tx_ack) begin
      if (exp_q.size() == 0) chk("R5 unexpected accept idx", int'(tx_idx), -1);
      else chk("R2 accepted idx", int'(tx_idx), exp_q.pop_front());
    end
  end

  // 0 done, 1 error, 2 lost
  task automatic result(input int kind);
    tx_done = (kind == 0);
    tx_err  = (kind == 1);
    tx_lost = (kind == 2);
    step();
    tx_done = 1'b0; tx_err = 1'b0; tx_lost = 1'b0;
  endtask

  // Driver: push expected index, accept the offer, optionally report a result.
  task automatic send(input int exp, input int kind);
    int n = 0;
    while (!tx_start && n < 20) begin step(); n++; end
    exp_q.push_back(exp);
    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;
    if (kind <= 2) result(kind);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      if (exp_q.size() != 0) chk("R2 scoreboard drained", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
        report();
      end
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 req_q", int'(req_q), 0);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 flags", int'({abt_q, lost_q, err_q, done_irq}), 0);
    chk("R1 pri_q", int'(pri_q), 0);
    chk("R1 abort_all_q", int'(abort_all_q), 0);

    // R12: ack and results with nothing offered are ignored
    tx_ack = 1'b1; tx_done = 1'b1; step(); tx_ack = 1'b0; tx_done = 1'b0;
    chk("R12 idle ack ignored", int'(tx_start), 0);
    chk("R12 idle done ignored", int'(done_irq), 0);

    // R2: priorities buf0=1 buf1=3 buf2=2
    done_ie = 3'b111;
    pri_we = 3'b111; pri_wdata = {2'd2, 2'd3, 2'd1}; step(); pri_we = '0;
    req_set = 3'b111; step(); req_set = '0;
    chk("R2 start same edge", int'(tx_start), 1);
    chk("R2 highest idx", int'(tx_idx), 1);
    send(1, 0);
    chk("R6 req cleared", int'(req_q), 3'b101);
    chk("R6 irq set", int'(done_irq), 3'b010);
    send(2, 0);
    send(0, 0);
    chk("R2 all sent", int'(req_q), 0);
    chk("R6 all irq", int'(done_irq), 3'b111);
    chk("R2 start low", int'(tx_start), 0);
    done_clr = 3'b111; step(); done_clr = '0;
    chk("R6 done_clr", int'(done_irq), 0);

    // R3: tie goes to lowest index
    pri_we = 3'b111; pri_wdata = {2'd2, 2'd2, 2'd2}; step(); pri_we = '0;
    req_set = 3'b110; step(); req_set = '0;
    chk("R3 tie idx", int'(tx_idx), 1);
    send(1, 0);
    send(2, 0);
    done_clr = 3'b111; step(); done_clr = '0;

    // R5: late priority change, then frozen after accept
    pri_we = 3'b011; pri_wdata = {2'd0, 2'd1, 2'd0}; step(); pri_we = '0;
    req_set = 3'b011; step(); req_set = '0;
    chk("R5 initial idx", int'(tx_idx), 1);
    pri_we = 3'b001; pri_wdata = {2'd0, 2'd1, 2'd3}; step(); pri_we = '0;
    chk("R5 idx follows pri", int'(tx_idx), 0);
    chk("R5 still offering", int'(tx_start), 1);
    send(0, 3);
    chk("R5 start drops", int'(tx_start), 0);
    pri_we = 3'b011; pri_wdata = {2'd0, 2'd3, 2'd0}; step(); pri_we = '0;
    result(0);
    chk("R5 frozen buffer done", int'(req_q), 3'b010);
    send(1, 0);
    done_clr = 3'b111; step(); done_clr = '0;

    // R7, R8, R4
    done_ie = 3'b001;
    pri_we = 3'b001; pri_wdata = {2'd0, 2'd0, 2'd3}; step(); pri_we = '0;
    req_set = 3'b001; step(); req_set = '0;
    send(0, 1);
    chk("R7 req stays", int'(req_q[0]), 1);
    chk("R7 err flag", int'(err_q[0]), 1);
    chk("R7 no irq", int'(done_irq[0]), 0);
    chk("R7 re-offered", int'(tx_start), 1);
    send(0, 2);
    chk("R8 lost flag", int'(lost_q[0]), 1);
    chk("R8 req stays", int'(req_q[0]), 1);
    chk("R8 no irq", int'(done_irq[0]), 0);
    req_set = 3'b001; step(); req_set = '0;
    chk("R4 flags cleared", int'({abt_q[0], lost_q[0], err_q[0]}), 0);
    send(0, 0);
    chk("R6 ie irq", int'(done_irq[0]), 1);
    done_clr = 3'b111; step(); done_clr = '0;

    // R6 with enable low
    done_ie = 3'b000;
    req_set = 3'b010; step(); req_set = '0;
    send(1, 0);
    chk("R6 no irq when disabled", int'(done_irq), 0);
    chk("R6 req cleared disabled", int'(req_q), 0);

    // R9 single abort while waiting, then R4 clears abort flag
    req_set = 3'b100; step(); req_set = '0;
    chk("R9 offered", int'(tx_idx), 2);
    req_clr = 3'b100; step(); req_clr = '0;
    chk("R9 req cleared", int'(req_q[2]), 0);
    chk("R9 abt set", int'(abt_q[2]), 1);
    chk("R9 start drops", int'(tx_start), 0);
    chk("R9 no irq", int'(done_irq[2]), 0);
    req_set = 3'b100; step(); req_set = '0;
    chk("R4 abt cleared", int'(abt_q[2]), 0);
    req_clr = 3'b100; step(); req_clr = '0;

    // R10 global abort with buf0 on the bus, which then fails (R11)
    pri_we = 3'b111; pri_wdata = {2'd1, 2'd2, 2'd3}; step(); pri_we = '0;
    req_set = 3'b111; step(); req_set = '0;
    send(0, 3);
    abort_all_set = 1'b1; step(); abort_all_set = 1'b0;
    chk("R10 waiting cancelled", int'(req_q), 3'b001);
    chk("R10 abt waiting", int'(abt_q), 3'b110);
    chk("R10 abort_all high", int'(abort_all_q), 1);
    step();
    chk("R10 abort_all held", int'(abort_all_q), 1);
    result(1);
    chk("R11 failed active aborted", int'(req_q), 0);
    chk("R11 abt on active", int'(abt_q), 3'b111);
    chk("R11 err on active", int'(err_q[0]), 1);
    chk("R10 abort_all cleared", int'(abort_all_q), 0);
    chk("R10 nothing offered", int'(tx_start), 0);

    // R11 aborted while on the bus, then completes
    done_ie = 3'b001;
    req_set = 3'b001; step(); req_set = '0;
    send(0, 3);
    req_clr = 3'b001; step(); req_clr = '0;
    chk("R11 req kept on bus", int'(req_q[0]), 1);
    result(0);
    chk("R11 completes req", int'(req_q[0]), 0);
    chk("R11 no abt", int'(abt_q[0]), 0);
    chk("R11 irq", int'(done_irq[0]), 1);
    done_clr = 3'b111; step(); done_clr = '0;

    // R10 idle: one-cycle pulse
    abort_all_set = 1'b1; step(); abort_all_set = 1'b0;
    chk("R10 idle high", int'(abort_all_q), 1);
    step();
    chk("R10 idle low", int'(abort_all_q), 0);

    // R12 result while only offered is ignored
    done_ie = 3'b010;
    req_set = 3'b010; step(); req_set = '0;
    tx_done = 1'b1; tx_err = 1'b1; step(); tx_done = 1'b0; tx_err = 1'b0;
    chk("R12 offer result req", int'(req_q), 3'b010);
    chk("R12 offer result irq", int'(done_irq), 0);
    chk("R12 offer result err", int'(err_q[1]), 0);
    chk("R12 still offering", int'(tx_start), 1);
    send(1, 0);
    chk("R12 then done", int'(done_irq), 3'b010);

    step(); step();
    report();
  end
endmodule